// File: doc/BRIEF.md
# Straw-Tube Time-over-Threshold Hit Formatter

This block turns a serialised stream of discriminator edge events from up to 32 straw-tube channels into compact hit records. Each event gives the channel, whether the edge is leading or trailing, and a fine time that an upstream converter has already digitised in 0.5 ns bins within the current 1 µs trigger-clock period. The block keeps one pending leading edge per channel. When the matching trailing edge arrives, it computes the time over threshold (TOT), which serves as a charge estimate. It then builds one record that holds the leading time, the TOT, a saturation flag, the channel, the trigger-period stamp of the leading edge and a fixed TDC identifier.

The trigger-period stamp is an 8-bit count of trigger-clock ticks within the current epoch. An epoch-start strobe clears it at every epoch boundary. Records leave in arrival order on a valid/ready stream, with a 16-entry FIFO to absorb back-pressure. Two saturating counters report hits lost to a full FIFO and leading edges that replaced an earlier unmatched leading edge.

Top module: `tot_hit_formatter`

## Requirements
- R1: The period stamp is 8 bits wide. It clears to 0 on `epoch_start_i`, which wins over a tick. Otherwise it increments modulo 256 on `trig_tick_i`. An edge event in the same cycle as a tick or epoch strobe uses the stamp value from before that update.
- R2: A leading edge (`evt_lead_i`=1) stores its time and the current stamp for its channel and marks the channel pending. It emits no record.
- R3: A trailing edge (`evt_lead_i`=0) on a pending channel with the same stamp as its leading edge emits one record with TOT = trailing time − leading time. It also clears the pending mark.
- R4: When the trailing stamp is exactly one above the leading stamp (modulo 256), the TOT is trailing time + 2000 − leading time.
- R5: If the TOT is above 255, or negative, or the stamps differ by two or more, the TOT field is 255 and the saturation bit is 1. Otherwise the saturation bit is 0.
- R6: A trailing edge on a channel with no pending leading edge produces no record and changes no counter.
- R7: A leading edge on a channel that is already pending replaces the stored time and stamp. It also increments `dbl_lead_cnt_o`, which saturates at all ones.
- R8: `hit_data_o` is 41 bits. From the top down, the fields are: [40:33] TDC identifier (default 0x5A), [32:25] leading-edge stamp, [24:20] channel, [19:9] leading time, [8:1] TOT, [0] saturation bit.
- R9: Records appear on `hit_data_o` in the order of their trailing edges, one cycle after the trailing edge. A record transfers when `hit_valid_o` and `hit_ready_i` are both high. While `hit_ready_i` is low, `hit_valid_o` and `hit_data_o` hold.
- R10: The FIFO holds 16 records. A record that arrives while 16 are held and none leaves that cycle is dropped, and `drop_cnt_o` increments (saturating). If a record leaves in the same cycle, the new record is accepted.
- R11: After reset, `hit_valid_o` is 0, both counters are 0, no channel is pending and the stamp is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_tick_i | input | 1 | One-cycle strobe at each trigger-clock period boundary |
| epoch_start_i | input | 1 | One-cycle strobe that clears the period stamp |
| evt_valid_i | input | 1 | Edge event present |
| evt_lead_i | input | 1 | 1 = leading edge, 0 = trailing edge |
| evt_chan_i | input | 5 | Channel number of the event |
| evt_time_i | input | 11 | Fine time in 0.5 ns bins within the period (0..1999) |
| hit_valid_o | output | 1 | Record available |
| hit_ready_i | input | 1 | Downstream accepts a record |
| hit_data_o | output | 41 | Hit record |
| dbl_lead_cnt_o | output | 16 | Count of replaced leading edges |
| drop_cnt_o | output | 16 | Count of records dropped on a full FIFO |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a trigger tick (or epoch strobe) and an edge event. The bench drives a leading edge in the very cycle of a tick. It then expects the record's stamp to be the pre-tick value and the TOT to include the one-period carry.

The second pair is a FIFO push and a pop while the FIFO is full. The bench fills the FIFO with `hit_ready_i` low, confirms that one further record is dropped and counted, and then raises ready in the same cycle as a new trailing edge. That record must be accepted and later drained in order, with `drop_cnt_o` unchanged.

// File: rtl/tot_fmt_pkg.sv
package tot_fmt_pkg;
  localparam int TIME_W  = 11;
  localparam int TOT_W   = 8;
  localparam int STAMP_W = 8;
  localparam int ID_W    = 8;
  localparam int CH_W    = 5;

  typedef struct packed {
    logic [ID_W-1:0]    tdc_id;
    logic [STAMP_W-1:0] stamp;
    logic [CH_W-1:0]    chan;
    logic [TIME_W-1:0]  lead_time;
    logic [TOT_W-1:0]   tot;
    logic               sat;
  } hit_rec_t;

  localparam int REC_W = $bits(hit_rec_t);
endpackage

// File: rtl/tot_stamp_ctr.sv
module tot_stamp_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         epoch_i,
  output logic [W-1:0] stamp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stamp_o <= '0;
    else if (epoch_i)  stamp_o <= '0;
    else if (tick_i)   stamp_o <= stamp_o + W'(1);
  end

  // R1
  epoch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_i |=> stamp_o == '0);

  // R1
  tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !epoch_i) |=> stamp_o == $past(stamp_o) + W'(1));
endmodule

// File: rtl/tot_chan_pair.sv
module tot_chan_pair
  import tot_fmt_pkg::*;
#(
  parameter int                NUM_CH      = 32,
  parameter int                PERIOD_BINS = 2000,
  parameter int                CNT_W       = 16,
  parameter logic [ID_W-1:0]   TDC_ID      = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic               evt_lead_i,
  input  logic [CH_W-1:0]    evt_chan_i,
  input  logic [TIME_W-1:0]  evt_time_i,
  input  logic [STAMP_W-1:0] stamp_i,
  output logic               rec_valid_o,
  output hit_rec_t           rec_o,
  output logic [CNT_W-1:0]   err_cnt_o
);
  localparam int RAW_W   = TIME_W + 2;
  localparam int TOT_MAX = 2**TOT_W - 1;

  logic [NUM_CH-1:0] pend_w;
  logic [TIME_W-1:0] lt_w [NUM_CH];
  logic [STAMP_W-1:0] ls_w [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic               sel;
    logic               pend_r;
    logic [TIME_W-1:0]  lt_r;
    logic [STAMP_W-1:0] ls_r;
    assign sel = evt_valid_i && (evt_chan_i == CH_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_r <= 1'b0;
        lt_r   <= '0;
        ls_r   <= '0;
      end else if (sel && evt_lead_i) begin
        pend_r <= 1'b1;
        lt_r   <= evt_time_i;
        ls_r   <= stamp_i;
      end else if (sel) begin
        pend_r <= 1'b0;
      end
    end
    assign pend_w[c] = pend_r;
    assign lt_w[c]   = lt_r;
    assign ls_w[c]   = ls_r;
  end

  logic               cur_pend;
  logic [TIME_W-1:0]  cur_lt;
  logic [STAMP_W-1:0] cur_ls, d_stamp;
  logic [RAW_W-1:0]   lead_ext, trail_ext, span;
  logic               over;

  always_comb begin
    cur_pend  = pend_w[evt_chan_i];
    cur_lt    = lt_w[evt_chan_i];
    cur_ls    = ls_w[evt_chan_i];
    d_stamp   = stamp_i - cur_ls;
    lead_ext  = RAW_W'(cur_lt);
    trail_ext = RAW_W'(evt_time_i) + ((d_stamp == STAMP_W'(1)) ? RAW_W'(PERIOD_BINS) : '0);
    span      = trail_ext - lead_ext;
    over      = (d_stamp > STAMP_W'(1)) || (trail_ext < lead_ext) || (span > RAW_W'(TOT_MAX));
  end

  assign rec_valid_o     = evt_valid_i && !evt_lead_i && cur_pend;
  assign rec_o.tdc_id    = TDC_ID;
  assign rec_o.stamp     = cur_ls;
  assign rec_o.chan      = evt_chan_i;
  assign rec_o.lead_time = cur_lt;
  assign rec_o.tot       = over ? '1 : span[TOT_W-1:0];
  assign rec_o.sat       = over;

  logic dbl;
  assign dbl = evt_valid_i && evt_lead_i && cur_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      err_cnt_o <= '0;
    else if (dbl && err_cnt_o != '1)  err_cnt_o <= err_cnt_o + CNT_W'(1);
  end

  // R5
  sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_o.sat) |-> rec_o.tot == '1);

  // R7
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbl && err_cnt_o != '1) |=> err_cnt_o == $past(err_cnt_o) + CNT_W'(1));

  // R6
  orphan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !(rec_valid_o && rec_o.chan == $past(rec_o.chan)));
endmodule

// File: rtl/tot_hit_fifo.sv
module tot_hit_fifo #(
  parameter int W     = 41,
  parameter int DEPTH = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] drop_cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] occ;
  logic             full, pop, accept, drop;

  assign full    = (occ == OCC_W'(DEPTH));
  assign valid_o = (occ != '0);
  assign pop     = valid_o && ready_i;
  assign accept  = push_i && (!full || pop);
  assign drop    = push_i && full && !pop;
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      occ        <= '0;
      drop_cnt_o <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)    rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({accept, pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
      if (drop && drop_cnt_o != '1) drop_cnt_o <= drop_cnt_o + CNT_W'(1);
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  // R10
  drop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !ready_i && drop_cnt_o != '1) |=> drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1));

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= OCC_W'(DEPTH));
endmodule

// File: rtl/tot_hit_formatter.sv
module tot_hit_formatter
  import tot_fmt_pkg::*;
#(
  parameter int              NUM_CH      = 32,
  parameter int              PERIOD_BINS = 2000,
  parameter int              FIFO_DEPTH  = 16,
  parameter int              CNT_W       = 16,
  parameter logic [ID_W-1:0] TDC_ID      = 8'h5A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_tick_i,
  input  logic               epoch_start_i,
  input  logic               evt_valid_i,
  input  logic               evt_lead_i,
  input  logic [CH_W-1:0]    evt_chan_i,
  input  logic [TIME_W-1:0]  evt_time_i,
  output logic               hit_valid_o,
  input  logic               hit_ready_i,
  output logic [REC_W-1:0]   hit_data_o,
  output logic [CNT_W-1:0]   dbl_lead_cnt_o,
  output logic [CNT_W-1:0]   drop_cnt_o
);
  logic [STAMP_W-1:0] stamp;
  logic               rec_valid;
  hit_rec_t           rec;

  tot_stamp_ctr #(.W(STAMP_W)) u_stamp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (trig_tick_i),
    .epoch_i (epoch_start_i),
    .stamp_o (stamp)
  );

  tot_chan_pair #(
    .NUM_CH      (NUM_CH),
    .PERIOD_BINS (PERIOD_BINS),
    .CNT_W       (CNT_W),
    .TDC_ID      (TDC_ID)
  ) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_valid_i (evt_valid_i),
    .evt_lead_i  (evt_lead_i),
    .evt_chan_i  (evt_chan_i),
    .evt_time_i  (evt_time_i),
    .stamp_i     (stamp),
    .rec_valid_o (rec_valid),
    .rec_o       (rec),
    .err_cnt_o   (dbl_lead_cnt_o)
  );

  tot_hit_fifo #(
    .W     (REC_W),
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rec_valid),
    .data_i     (rec),
    .valid_o    (hit_valid_o),
    .ready_i    (hit_ready_i),
    .data_o     (hit_data_o),
    .drop_cnt_o (drop_cnt_o)
  );
endmodule

// File: tb/tot_hit_formatter_tb.sv
module tot_hit_formatter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, epoch = 1'b0;
  logic        evt_valid = 1'b0, evt_lead = 1'b0;
  logic [4:0]  evt_chan = '0;
  logic [10:0] evt_time = '0;
  logic        hit_ready = 1'b1;
  logic        hit_valid;
  logic [40:0] hit_data;
  logic [15:0] dbl_cnt, drop_cnt;

  always #4 clk = ~clk;

  tot_hit_formatter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_tick_i(tick), .epoch_start_i(epoch),
    .evt_valid_i(evt_valid), .evt_lead_i(evt_lead), .evt_chan_i(evt_chan),
    .evt_time_i(evt_time), .hit_valid_o(hit_valid), .hit_ready_i(hit_ready),
    .hit_data_o(hit_data), .dbl_lead_cnt_o(dbl_cnt), .drop_cnt_o(drop_cnt)
  );

  int checks = 0, errors = 0;
  int stamp_m = 0, err_m = 0, drop_m = 0;
  int m_pend[32], m_lt[32], m_ls[32];
  logic [40:0] exp_q[$];

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [40:0] mk(int ch, int l, int ls, int t, int ts);
    int d = (ts - ls + 256) % 256;
    int span = -1;
    bit sat;
    if (d == 0) span = t - l;
    else if (d == 1) span = t + 2000 - l;
    sat = (span < 0) || (span > 255);
    return {8'h5A, 8'(ls), 5'(ch), 11'(l), sat ? 8'hFF : 8'(span), sat};
  endfunction

  // R9 R8 R3 R4 R5: every transferred or stalled record is compared with the model
  always @(negedge clk) begin
    if (rst_n && hit_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected record", 64'(hit_data), 64'h0 - 1);
      else begin
        chk("R9 record", 64'(hit_data), 64'(exp_q[0]));
        if (hit_ready) void'(exp_q.pop_front());
      end
    end
  end

  task automatic step(input bit vld, input int ch, input bit ld, input int t,
                      input bit tk, input bit ep);
    evt_valid = vld; evt_lead = ld; evt_chan = 5'(ch); evt_time = 11'(t);
    tick = tk; epoch = ep;
    if (vld) begin
      if (ld) begin
        if (m_pend[ch] != 0 && err_m < 65535) err_m++;
        m_pend[ch] = 1; m_lt[ch] = t; m_ls[ch] = stamp_m;
      end else if (m_pend[ch] != 0) begin
        m_pend[ch] = 0;
        if (exp_q.size() >= 16 && !(hit_ready && exp_q.size() > 0)) drop_m++;
        else exp_q.push_back(mk(ch, m_lt[ch], m_ls[ch], t, stamp_m));
      end
    end
    if (ep) stamp_m = 0;
    else if (tk) stamp_m = (stamp_m + 1) % 256;
    @(posedge clk); #1;
    evt_valid = 1'b0; tick = 1'b0; epoch = 1'b0;
  endtask

  task automatic ev(input int ch, input bit ld, input int t, input bit tk);
    step(1'b1, ch, ld, t, tk, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic drain();
    hit_ready = 1'b1;
    for (int i = 0; i < 40 && exp_q.size() > 0; i++) idle(1);
    idle(2);
    chk("R9 drained", 64'(exp_q.size()), 64'd0);
    chk("R9 valid low", 64'(hit_valid), 64'd0);
  endtask

  bit done = 1'b0;
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_pend[i] = 0; m_lt[i] = 0; m_ls[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11
    chk("R11 valid", 64'(hit_valid), 64'd0);
    chk("R11 dbl cnt", 64'(dbl_cnt), 64'd0);
    chk("R11 drop cnt", 64'(drop_cnt), 64'd0);
    ev(2, 1'b0, 10, 1'b0);   // R11 no channel pending: orphan after reset
    idle(2);
    chk("R11 no record", 64'(hit_valid), 64'd0);

    // R2 R3 R5 R8: every channel, varied widths incl. saturation
    for (int ch = 0; ch < 32; ch++) begin
      int l = (ch * 61) % 1700;
      ev(ch, 1'b1, l, 1'b0);
      ev(ch, 1'b0, l + (ch * 23) % 320, 1'b0);
    end
    drain();
    // R3 R5 width sweep on one channel
    for (int w = 0; w <= 300; w += 5) begin
      ev(0, 1'b1, 100, 1'b0);
      ev(0, 1'b0, 100 + w, 1'b0);
    end
    ev(0, 1'b1, 1000, 1'b0); ev(0, 1'b0, 1255, 1'b0);   // R5 exactly 255
    ev(0, 1'b1, 1000, 1'b0); ev(0, 1'b0, 1256, 1'b0);   // R5 256 saturates
    drain();

    // R4 R1 lead in the tick cycle takes pre-tick stamp
    ev(3, 1'b1, 1990, 1'b1); ev(3, 1'b0, 5, 1'b0);
    ev(4, 1'b1, 1900, 1'b1); ev(4, 1'b0, 1950, 1'b0);   // R5 carried span too wide
    ev(5, 1'b1, 10, 1'b0);
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0); step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    ev(5, 1'b0, 20, 1'b0);                              // R5 two periods apart
    ev(7, 1'b1, 500, 1'b0); ev(7, 1'b0, 400, 1'b0);     // R5 negative
    drain();

    // R1 epoch clear (wins over tick), then wrap at 256
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b1);
    ev(8, 1'b1, 30, 1'b0); ev(8, 1'b0, 40, 1'b0);
    for (int i = 0; i < 255; i++) step(1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    ev(8, 1'b1, 30, 1'b1); ev(8, 1'b0, 50, 1'b0);       // R1 stamp 255 -> 0 carry
    ev(8, 1'b1, 60, 1'b0); ev(8, 1'b0, 70, 1'b0);       // R1 stamp wrapped to 0
    drain();

    // R6 orphan trailing edges
    ev(9, 1'b1, 100, 1'b0); ev(9, 1'b0, 120, 1'b0); ev(9, 1'b0, 130, 1'b0);
    ev(11, 1'b0, 40, 1'b0);
    drain();
    chk("R6 dbl cnt untouched", 64'(dbl_cnt), 64'd0);
    chk("R6 drop cnt untouched", 64'(drop_cnt), 64'd0);

    // R7 replaced leading edge
    ev(10, 1'b1, 100, 1'b0); ev(10, 1'b1, 300, 1'b0); ev(10, 1'b0, 350, 1'b0);
    drain();
    chk("R7 dbl cnt", 64'(dbl_cnt), 64'(err_m));
    chk("R7 dbl cnt one", 64'(dbl_cnt), 64'd1);

    // R10 fill, drop one, then push with simultaneous pop
    hit_ready = 1'b0;
    for (int k = 0; k < 17; k++) begin
      ev(k, 1'b1, 10 * k, 1'b0); ev(k, 1'b0, 10 * k + k + 1, 1'b0);
    end
    chk("R10 drop cnt", 64'(drop_cnt), 64'd1);
    chk("R10 valid full", 64'(hit_valid), 64'd1);
    ev(20, 1'b1, 700, 1'b0);
    hit_ready = 1'b1;
    ev(20, 1'b0, 777, 1'b0);
    idle(1);
    chk("R10 no drop on pop", 64'(drop_cnt), 64'd1);
    drain();
    chk("R10 drop model", 64'(drop_cnt), 64'(drop_m));
    chk("R7 dbl final", 64'(dbl_cnt), 64'(err_m));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule